// File: doc/BRIEF.md
# Reloading Countdown Alarm Timer

This block is a periodic alarm built on a 24-bit binary down-counter. Software loads a reload value (the seed) through a byte-wide register port and turns on counting. After that, the counter steps down by one on every cycle in which the `tick` input is high. When the count runs out, a sticky alarm flag is raised, the seed is loaded again and counting continues. The result is an alarm that repeats every `seed` ticks with no further attention from software.

An active-low interrupt line follows the flag while two control bits allow it. Software clears the flag by writing 0 to it. A read of the least significant counter byte latches the whole live count into a snapshot. The two higher bytes are then read from that snapshot, so a three-byte read gives one consistent value while the live counter keeps running.

Top module: `alarm_countdown_timer`

## Requirements
- R1: A synchronous active-high `rst` clears the seed, counter, control bits, flag and snapshot. During and after reset `irq_n` is high and every register reads 0.
- R2: Writes to addresses 04h, 05h and 06h store bits 7:0, 15:8 and 23:16 of the seed. A seed write does not change a counter that is already running until its next reload.
- R3: The control byte is at 07h: bit 6 is the count enable, bit 2 the interrupt mode select and bit 0 the interrupt enable. Its other bits read as 0. The status byte is at 08h with the alarm flag at bit 0; its bits 7:1 read as 0.
- R4: A control write that takes the enable from 0 to 1 loads the current seed into the counter. A control write while the enable is already 1 does not reload.
- R5: In a cycle with `tick` high, the enable set and a nonzero seed, the counter decrements by one. It holds its value when `tick` is low, when the enable is 0, or when the seed is 0.
- R6: On a counting tick in which the count is 1 or less, the flag is set and the seed is reloaded in place of the decrement. The alarm therefore repeats every `seed` ticks.
- R7: The flag is sticky. Writing 0 to status bit 0 clears it, and writing 1 has no effect. If a new expiry falls in the same cycle as a clear, the flag stays set.
- R8: `irq_n` is low exactly when the flag, the interrupt mode select and the interrupt enable are all 1. Otherwise it is high.
- R9: A read of 04h returns bits 7:0 of the live count and captures all 24 bits into a snapshot. Reads of 05h and 06h return the snapshot bytes even if the counter has moved since.
- R10: `rdata` is valid in the cycle after `rd_en` and holds its value until the next read. Addresses outside 04h–08h read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count strobe, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The hardest case to reach is an expiry that lands in the same cycle as a software clear of an already set flag. The count must sit at exactly 1 at that moment. The bench sets the seed to 1 so that every counting tick expires. It lets one tick set the flag, then issues the status clear in the same cycle as the next tick. A second hard case is a snapshot across a borrow: the seed 010000h is read one byte at a time with a tick in between, so the live value drops to 00FFFFh while the upper bytes must still come from the snapshot.

// File: rtl/alarm_timer_pkg.sv
package alarm_timer_pkg;
    // control byte field positions (fixed by the register layout)
    localparam int CTRL_EN_BIT   = 6;
    localparam int CTRL_MODE_BIT = 2;
    localparam int CTRL_IE_BIT   = 0;
    localparam int STAT_FLAG_BIT = 0;

    typedef struct packed {
        logic en;
        logic mode;
        logic ie;
    } ctrl_t;
endpackage

// File: rtl/alarm_down_counter.sv
module alarm_down_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             enable,
    input  logic             load,
    input  logic [CNT_W-1:0] seed,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       run;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        run    = enable && (seed != '0);
        if (load) begin
            st_d.cnt = seed;
        end else if (tick && run) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                expire   = 1'b1;
                st_d.cnt = seed;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R4
    load_seed_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(seed));

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> count == $past(seed));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(count));
endmodule

// File: rtl/alarm_csr.sv
module alarm_csr
    import alarm_timer_pkg::*;
#(
    parameter int CNT_BYTES = 3,
    parameter int ADDR_W    = 5,
    parameter int BASE      = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wdata,
    input  logic [8*CNT_BYTES-1:0] count,
    input  logic                   expire,
    output logic [8*CNT_BYTES-1:0] seed,
    output logic                   enable,
    output logic                   load,
    output logic [7:0]             rdata,
    output logic                   irq_n
);
    localparam int CNT_W     = 8 * CNT_BYTES;
    localparam int CTRL_ADDR = BASE + CNT_BYTES;
    localparam int STAT_ADDR = CTRL_ADDR + 1;

    typedef struct packed {
        logic [CNT_W-1:0] seed;
        ctrl_t            ctrl;
        logic             flag;
        logic [CNT_W-1:0] snap;
        logic [7:0]       rdata;
    } csr_state_t;

    csr_state_t st_d, st_q;

    logic [CNT_BYTES-1:0] byte_wr;
    logic [CNT_BYTES-1:0] byte_rd;
    logic                 ctrl_wr;
    logic                 stat_clr;

    // one address decoder per counter byte
    for (genvar g = 0; g < CNT_BYTES; g++) begin : g_byte_dec
        assign byte_wr[g] = wr_en && (addr == ADDR_W'(BASE + g));
        assign byte_rd[g] = rd_en && (addr == ADDR_W'(BASE + g));
    end

    assign ctrl_wr  = wr_en && (addr == ADDR_W'(CTRL_ADDR));
    assign stat_clr = wr_en && (addr == ADDR_W'(STAT_ADDR)) && !wdata[STAT_FLAG_BIT];
    assign load     = ctrl_wr && wdata[CTRL_EN_BIT] && !st_q.ctrl.en;

    always_comb begin
        st_d = st_q;

        for (int i = 0; i < CNT_BYTES; i++) begin
            if (byte_wr[i]) st_d.seed[8*i +: 8] = wdata;
        end

        if (ctrl_wr) begin
            st_d.ctrl.en   = wdata[CTRL_EN_BIT];
            st_d.ctrl.mode = wdata[CTRL_MODE_BIT];
            st_d.ctrl.ie   = wdata[CTRL_IE_BIT];
        end

        // a fresh expiry outranks a clear in the same cycle
        st_d.flag = expire || (st_q.flag && !stat_clr);

        if (rd_en) begin
            st_d.rdata = 8'h00;
            if (byte_rd[0]) begin
                st_d.snap  = count;
                st_d.rdata = count[7:0];
            end
            for (int i = 1; i < CNT_BYTES; i++) begin
                if (byte_rd[i]) st_d.rdata = st_q.snap[8*i +: 8];
            end
            if (addr == ADDR_W'(CTRL_ADDR)) begin
                st_d.rdata                = 8'h00;
                st_d.rdata[CTRL_EN_BIT]   = st_q.ctrl.en;
                st_d.rdata[CTRL_MODE_BIT] = st_q.ctrl.mode;
                st_d.rdata[CTRL_IE_BIT]   = st_q.ctrl.ie;
            end
            if (addr == ADDR_W'(STAT_ADDR)) begin
                st_d.rdata                = 8'h00;
                st_d.rdata[STAT_FLAG_BIT] = st_q.flag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign seed   = st_q.seed;
    assign enable = st_q.ctrl.en;
    assign rdata  = st_q.rdata;
    assign irq_n  = !(st_q.flag && st_q.ctrl.mode && st_q.ctrl.ie);

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> st_q.flag);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.flag && !(wr_en && addr == ADDR_W'(STAT_ADDR) && !wdata[STAT_FLAG_BIT]))
        |=> st_q.flag);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !st_q.flag |-> irq_n);

    // R9
    snap_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(BASE)) |=> st_q.snap == $past(count));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

// File: rtl/alarm_countdown_timer.sv
module alarm_countdown_timer #(
    parameter int CNT_BYTES = 3,
    parameter int ADDR_W    = 5,
    parameter int BASE      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              irq_n
);
    localparam int CNT_W = 8 * CNT_BYTES;

    logic [CNT_W-1:0] seed;
    logic [CNT_W-1:0] count;
    logic             enable;
    logic             load;
    logic             expire;

    alarm_csr #(
        .CNT_BYTES (CNT_BYTES),
        .ADDR_W    (ADDR_W),
        .BASE      (BASE)
    ) u_csr (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .count  (count),
        .expire (expire),
        .seed   (seed),
        .enable (enable),
        .load   (load),
        .rdata  (rdata),
        .irq_n  (irq_n)
    );

    alarm_down_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .enable (enable),
        .load   (load),
        .seed   (seed),
        .count  (count),
        .expire (expire)
    );

    // R1
    reset_irq_chk: assert property (@(posedge clk)
        $past(rst) |-> irq_n);
endmodule

// File: tb/alarm_countdown_timer_tb.sv
`timescale 1ns/1ps
module alarm_countdown_timer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    alarm_countdown_timer u_dut (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq_n (irq_n)
    );

    localparam logic [1:0] OP_T = 2'd0;  // data = number of ticks
    localparam logic [1:0] OP_W = 2'd1;  // write data to addr
    localparam logic [1:0] OP_R = 2'd2;  // read addr, expect data
    localparam int NV = 18;
    // R2 R5 R6: seed 5, count down, expire and reload
    localparam logic [14:0] VECS [0:NV-1] = '{
        {OP_W, 5'h04, 8'h05}, {OP_W, 5'h05, 8'h00}, {OP_W, 5'h06, 8'h00},
        {OP_W, 5'h07, 8'h45}, {OP_R, 5'h08, 8'h00}, {OP_T, 5'h00, 8'h02},
        {OP_R, 5'h04, 8'h03}, {OP_R, 5'h05, 8'h00}, {OP_R, 5'h06, 8'h00},
        {OP_T, 5'h00, 8'h02}, {OP_R, 5'h04, 8'h01}, {OP_R, 5'h08, 8'h00},
        {OP_T, 5'h00, 8'h01}, {OP_R, 5'h04, 8'h05}, {OP_R, 5'h08, 8'h01},
        {OP_T, 5'h00, 8'h05}, {OP_R, 5'h04, 8'h05}, {OP_R, 5'h07, 8'h45}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic [4:0] a,
                       input logic [7:0] d, input logic t);
        wr_en = w; rd_en = r; addr = a; wdata = d; tick = t;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        cyc(1'b1, 1'b0, a, d, 1'b0);
    endtask

    task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
        cyc(1'b0, 1'b1, a, 8'h00, 1'b0);
        chk(tag, rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 5'h00, 8'h00, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq_n in reset", {7'b0, irq_n}, 8'h01);
        rst = 1'b0;
        rd(5'h04, 8'h00, "R1 count after reset");
        rd(5'h07, 8'h00, "R1 ctrl after reset");
        rd(5'h08, 8'h00, "R1 status after reset");

        for (int v = 0; v < NV; v++) begin
            case (VECS[v][14:13])
                OP_T: ticks(int'(VECS[v][7:0]));
                OP_W: wr(VECS[v][12:8], VECS[v][7:0]);
                default: rd(VECS[v][12:8], VECS[v][7:0], $sformatf("R6 table step %0d", v));
            endcase
        end

        // R8 interrupt gating, flag is set here
        chk("R8 irq low with both enables", {7'b0, irq_n}, 8'h00);
        wr(5'h07, 8'h41);
        chk("R8 irq high without mode", {7'b0, irq_n}, 8'h01);
        wr(5'h07, 8'h44);
        chk("R8 irq high without enable", {7'b0, irq_n}, 8'h01);
        wr(5'h07, 8'h45);
        chk("R8 irq low again", {7'b0, irq_n}, 8'h00);
        // R7 writing 1 does nothing, writing 0 clears
        wr(5'h08, 8'h01);
        rd(5'h08, 8'h01, "R7 write 1 keeps flag");
        wr(5'h08, 8'hFE);
        rd(5'h08, 8'h00, "R7 write 0 clears flag");
        chk("R8 irq released after clear", {7'b0, irq_n}, 8'h01);

        // R4 rewriting enable while set: no reload
        rd(5'h04, 8'h05, "R4 count before");
        ticks(2);
        wr(5'h07, 8'h45);
        rd(5'h04, 8'h03, "R4 no reload while enabled");
        // R5 disabled counter holds
        wr(5'h07, 8'h05);
        ticks(2);
        rd(5'h04, 8'h03, "R5 hold while disabled");
        wr(5'h07, 8'h45);
        rd(5'h04, 8'h05, "R4 reload on enable rise");

        // R7 expiry in same cycle as clear keeps flag (seed 1)
        wr(5'h04, 8'h01);
        rd(5'h04, 8'h05, "R2 seed write leaves running count");
        ticks(4);
        rd(5'h08, 8'h00, "R6 no flag before expiry");
        ticks(1);
        rd(5'h08, 8'h01, "R6 flag on expiry");
        cyc(1'b1, 1'b0, 5'h08, 8'h00, 1'b1);
        rd(5'h08, 8'h01, "R7 set wins over clear");
        wr(5'h08, 8'h00);
        rd(5'h08, 8'h00, "R7 clear without expiry");

        // R5 zero seed never counts or flags
        wr(5'h07, 8'h00);
        wr(5'h04, 8'h00);
        wr(5'h07, 8'h40);
        ticks(3);
        rd(5'h04, 8'h00, "R5 zero seed count");
        rd(5'h08, 8'h00, "R5 zero seed no flag");

        // R9 snapshot across a borrow, R2 byte order
        wr(5'h07, 8'h00);
        wr(5'h06, 8'h01);
        wr(5'h07, 8'h40);
        rd(5'h04, 8'h00, "R9 low byte live");
        ticks(1);
        rd(5'h05, 8'h00, "R9 mid byte from snapshot");
        rd(5'h06, 8'h01, "R9 high byte from snapshot");
        rd(5'h04, 8'hFF, "R9 new low byte");
        rd(5'h05, 8'hFF, "R9 new mid byte");
        rd(5'h06, 8'h00, "R2 new high byte");

        // R3 reserved bits, R10 unmapped and hold
        wr(5'h07, 8'hFF);
        rd(5'h07, 8'h45, "R3 ctrl reserved bits zero");
        rd(5'h10, 8'h00, "R10 unmapped reads zero");
        rd(5'h07, 8'h45, "R10 ctrl read");
        cyc(1'b0, 1'b0, 5'h00, 8'h00, 1'b0);
        chk("R10 rdata holds", rdata, 8'h45);

        // R1 reset in mid-run clears all
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(5'h07, 8'h00, "R1 ctrl cleared");
        rd(5'h05, 8'h00, "R1 snapshot cleared");
        chk("R1 irq_n high", {7'b0, irq_n}, 8'h01);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule